// File: doc/BRIEF.md
# RAM DAC Address Scan Controller

This block produces the address pointer for a 64-entry waveform memory whose output feeds a DAC. Software programs one 8-bit control register. The register sets a scan rate divided down from the master clock, a scan direction, end-of-range handling, an overall enable, and the host-side rules for accessing the memory. While enabled, the pointer takes one step on every scan tick. It either stops at the end of the range or bounces back and forth to form a continuous triangle ramp.

When host access is on, the host can also walk the same pointer through the memory. Each host read strobe or each host write strobe advances it by one; a register bit chooses which strobe counts. A control write with host access turned off returns the pointer to location 0. The memory array and the converter are outside this block.

Top module: `ramdac_scan_ctrl`

## Requirements
- R1: After synchronous reset the control register is 0x00, the pointer is 0, the scan direction is downward and `scan_tick` is 0.
- R2: A write reaches the control register only when `cfg_addr` equals 0x10. A write to any other address leaves the register and the pointer unchanged.
- R3: The prescaler is a free-running 10-bit counter that starts at 0 after reset. The rate code in control bits [5:3] selects a period of 1024 >> code cycles. `scan_tick` is a one-cycle pulse in each cycle where the low (10 − code) counter bits are all ones.
- R4: While control bit 0 (enable) is 0, `scan_tick` stays 0 and the pointer does not move unless the host or a control write moves it.
- R5: On a scan tick the pointer moves one step. It moves up (+1) when the scan direction is upward and down (−1) when it is downward.
- R6: With control bit 1 (auto-cycle) at 0, a tick at location 63 while moving up, or at location 0 while moving down, leaves the pointer where it is.
- R7: With auto-cycle at 1, a tick at 63 while moving up sets the direction downward and the pointer to 62. A tick at 0 while moving down sets the direction upward and the pointer to 1.
- R8: While control bit 6 (host access) is 1, a host strobe advances the pointer by one, wrapping from 63 to 0. If control bit 7 is 1, `host_rd` advances the pointer and `host_wr` is ignored. If control bit 7 is 0, `host_wr` advances it and `host_rd` is ignored. While bit 6 is 0, both strobes are ignored.
- R9: A control write whose bit 6 is 0 clears the pointer to 0 at the next edge. In any control-write cycle, host strobes and scan ticks do not move the pointer.
- R10: When a host step and a scan tick fall in the same cycle, only the host step takes effect.
- R11: Every control write loads the scan direction from bit 2 (1 = upward, 0 = downward).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| host_rd | input | 1 | Host memory read strobe |
| host_wr | input | 1 | Host memory write strobe |
| ram_addr | output | 6 | Waveform memory address pointer |
| scan_tick | output | 1 | One-cycle scan step pulse |

## Verification
The assertions check, on every cycle:
- a tick never follows a tick and never appears while the enable is off;
- a misaddressed write changes nothing;
- a clearing write zeroes the pointer;
- a host step adds exactly one;
- the pointer holds at an end with auto-cycle off and reverses at the top with it on;
- the direction follows every control write.

The exact spacing of ticks for each rate code, the alignment of the first tick with the prescaler phase, and the full triangle ramp can only be shown by the bench's scenarios. The same holds for strobe selection under both settings of bit 7 and for host steps that override coinciding ticks. The bench shows these by running its cycle-level reference model alongside the design.

// File: rtl/ramdac_pkg.sv
package ramdac_pkg;

    localparam int PTR_W    = 6;
    localparam int PRESC_W  = 10;
    localparam int RATE_W   = 3;
    localparam int BUS_AW   = 8;
    localparam int CFG_W    = 5 + RATE_W;
    localparam logic [BUS_AW-1:0] CTRL_ADDR = 8'h10;

    // Control register layout, MSB first
    typedef struct packed {
        logic              inc_on_read;   // bit 7
        logic              access_en;     // bit 6
        logic [RATE_W-1:0] rate;          // bits 5:3
        logic              dir_up;        // bit 2
        logic              auto_cycle;    // bit 1
        logic              enable;        // bit 0
    } ramdac_cfg_t;

    typedef enum logic {
        SCAN_DOWN = 1'b0,
        SCAN_UP   = 1'b1
    } scan_dir_e;

    typedef enum logic [1:0] {
        ACT_HOLD,
        ACT_CLEAR,
        ACT_HOST,
        ACT_SCAN
    } ptr_act_e;

    function automatic ramdac_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        return ramdac_cfg_t'(raw);
    endfunction

    function automatic logic host_step_req(input logic access_en, input logic inc_on_read,
                                           input logic rd, input logic wr);
        return access_en && (inc_on_read ? rd : wr);
    endfunction

endpackage

// File: rtl/ramdac_cfg_reg.sv
module ramdac_cfg_reg
    import ramdac_pkg::*;
#(
    parameter int                BUS_AW_P = BUS_AW,
    parameter logic [BUS_AW_P-1:0] REG_ADDR = CTRL_ADDR
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [BUS_AW_P-1:0] cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output ramdac_cfg_t         cfg,
    output logic                load,
    output logic                load_clear,
    output logic                load_dir_up
);

    ramdac_cfg_t cfg_q;
    ramdac_cfg_t wr_cfg;

    always_comb begin
        wr_cfg      = decode_cfg(cfg_wdata);
        load        = cfg_we && (cfg_addr == REG_ADDR);
        load_clear  = load && !wr_cfg.access_en;
        load_dir_up = wr_cfg.dir_up;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= wr_cfg;
        end
    end

    assign cfg = cfg_q;

    // R2
    miss_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr != REG_ADDR) |=> $stable(cfg_q));

endmodule

// File: rtl/ramdac_prescaler.sv
module ramdac_prescaler
    import ramdac_pkg::*;
#(
    parameter int PRESC_W_P = PRESC_W,
    parameter int RATE_W_P  = RATE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic [RATE_W_P-1:0] rate,
    output logic                tick
);

    localparam int NUM_RATES = 1 << RATE_W_P;

    logic [PRESC_W_P-1:0] cnt_q;
    logic [NUM_RATES-1:0] stage_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Code g divides by 2**(PRESC_W_P-g): the low PRESC_W_P-g bits all set
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_stage
        assign stage_hit[g] = &cnt_q[PRESC_W_P-1-g:0];
    end

    assign tick = enable && stage_hit[rate];

    // R3
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R4
    tick_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> enable);

endmodule

// File: rtl/ramdac_scan_ptr.sv
module ramdac_scan_ptr
    import ramdac_pkg::*;
#(
    parameter int PTR_W_P = PTR_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               load_clear,
    input  logic               load_dir_up,
    input  logic               access_en,
    input  logic               inc_on_read,
    input  logic               auto_cycle,
    input  logic               host_rd,
    input  logic               host_wr,
    input  logic               tick,
    output logic [PTR_W_P-1:0] ptr,
    output logic               dir_up
);

    localparam logic [PTR_W_P-1:0] TOP = '1;
    localparam logic [PTR_W_P-1:0] BOT = '0;

    logic [PTR_W_P-1:0] ptr_q;
    scan_dir_e          dir_q;
    ptr_act_e           act;
    logic               host_step;
    logic [PTR_W_P-1:0] scan_ptr_n;
    scan_dir_e          scan_dir_n;

    always_comb begin
        host_step = host_step_req(access_en, inc_on_read, host_rd, host_wr);
        if (load) begin
            act = load_clear ? ACT_CLEAR : ACT_HOLD;
        end else if (host_step) begin
            act = ACT_HOST;
        end else if (tick) begin
            act = ACT_SCAN;
        end else begin
            act = ACT_HOLD;
        end
    end

    always_comb begin
        scan_ptr_n = ptr_q;
        scan_dir_n = dir_q;
        if (dir_q == SCAN_UP) begin
            if (ptr_q != TOP) begin
                scan_ptr_n = ptr_q + 1'b1;
            end else if (auto_cycle) begin
                scan_ptr_n = TOP - 1'b1;
                scan_dir_n = SCAN_DOWN;
            end
        end else begin
            if (ptr_q != BOT) begin
                scan_ptr_n = ptr_q - 1'b1;
            end else if (auto_cycle) begin
                scan_ptr_n = BOT + 1'b1;
                scan_dir_n = SCAN_UP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            dir_q <= SCAN_DOWN;
        end else begin
            unique case (act)
                ACT_CLEAR: ptr_q <= '0;
                ACT_HOST:  ptr_q <= ptr_q + 1'b1;
                ACT_SCAN: begin
                    ptr_q <= scan_ptr_n;
                    dir_q <= scan_dir_n;
                end
                default:   ptr_q <= ptr_q;
            endcase
            if (load) begin
                dir_q <= scan_dir_e'(load_dir_up);
            end
        end
    end

    assign ptr    = ptr_q;
    assign dir_up = (dir_q == SCAN_UP);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !host_step && !tick) |=> $stable(ptr_q));

    // R5
    scan_up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !host_step && tick && dir_q == SCAN_UP && ptr_q != TOP)
        |=> ptr_q == PTR_W_P'($past(ptr_q) + 1'b1));

    // R6
    top_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !host_step && tick && !auto_cycle && dir_q == SCAN_UP && ptr_q == TOP)
        |=> ptr_q == TOP);

    // R7
    top_bounce_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !host_step && tick && auto_cycle && dir_q == SCAN_UP && ptr_q == TOP)
        |=> (ptr_q == PTR_W_P'(TOP - 1'b1) && dir_q == SCAN_DOWN));

    // R8
    host_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && host_step) |=> ptr_q == PTR_W_P'($past(ptr_q) + 1'b1));

    // R9
    clear_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        load_clear |=> ptr_q == BOT);

endmodule

// File: rtl/ramdac_scan_ctrl.sv
module ramdac_scan_ctrl
    import ramdac_pkg::*;
#(
    parameter int                  BUS_AW_P  = BUS_AW,
    parameter logic [BUS_AW_P-1:0] REG_ADDR  = CTRL_ADDR,
    parameter int                  PTR_W_P   = PTR_W,
    parameter int                  PRESC_W_P = PRESC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [BUS_AW_P-1:0] cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    input  logic                host_rd,
    input  logic                host_wr,
    output logic [PTR_W_P-1:0]  ram_addr,
    output logic                scan_tick
);

    ramdac_cfg_t cfg;
    logic        load;
    logic        load_clear;
    logic        load_dir_up;
    logic        tick;
    logic        scan_dir_up;

    ramdac_cfg_reg #(
        .BUS_AW_P (BUS_AW_P),
        .REG_ADDR (REG_ADDR)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .cfg         (cfg),
        .load        (load),
        .load_clear  (load_clear),
        .load_dir_up (load_dir_up)
    );

    ramdac_prescaler #(
        .PRESC_W_P (PRESC_W_P),
        .RATE_W_P  (RATE_W)
    ) u_presc (
        .clk    (clk),
        .rst    (rst),
        .enable (cfg.enable),
        .rate   (cfg.rate),
        .tick   (tick)
    );

    ramdac_scan_ptr #(
        .PTR_W_P (PTR_W_P)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .load_clear  (load_clear),
        .load_dir_up (load_dir_up),
        .access_en   (cfg.access_en),
        .inc_on_read (cfg.inc_on_read),
        .auto_cycle  (cfg.auto_cycle),
        .host_rd     (host_rd),
        .host_wr     (host_wr),
        .tick        (tick),
        .ptr         (ram_addr),
        .dir_up      (scan_dir_up)
    );

    assign scan_tick = tick;

    // R11
    dir_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> scan_dir_up == cfg.dir_up);

endmodule

// File: tb/tb_ramdac_scan_ctrl.sv
module tb_ramdac_scan_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       host_rd = 1'b0;
    logic       host_wr = 1'b0;
    logic [5:0] ram_addr;
    logic       scan_tick;

    always #2 clk = ~clk;   // 250 MHz

    ramdac_scan_ctrl dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .ram_addr  (ram_addr),
        .scan_tick (scan_tick)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 0;
    string cur_req = "R1";

    // Behavioural reference state
    int       m_ptr = 0;
    int       m_dir = 0;
    int       m_cnt = 0;
    bit [7:0] m_ctrl = '0;

    function automatic bit exp_tick();
        int code = int'(m_ctrl[5:3]);
        int mask = (1024 >> code) - 1;
        return m_ctrl[0] && ((m_cnt & mask) == mask);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic model_adv(input bit we, input bit [7:0] a, input bit [7:0] d,
                             input bit rd, input bit wr);
        bit t = exp_tick();
        if (we && a == 8'h10) begin
            m_ctrl = d;
            m_dir  = int'(d[2]);
            if (!d[6]) m_ptr = 0;
        end else if (m_ctrl[6] && (m_ctrl[7] ? rd : wr)) begin
            m_ptr = (m_ptr + 1) % 64;
        end else if (t) begin
            if (m_dir == 1) begin
                if (m_ptr < 63) m_ptr++;
                else if (m_ctrl[1]) begin m_dir = 0; m_ptr = 62; end
            end else begin
                if (m_ptr > 0) m_ptr--;
                else if (m_ctrl[1]) begin m_dir = 1; m_ptr = 1; end
            end
        end
        m_cnt = (m_cnt + 1) % 1024;
    endtask

    task automatic step(input bit we, input bit [7:0] a, input bit [7:0] d,
                        input bit rd, input bit wr);
        @(negedge clk);
        chk({cur_req, " ram_addr"}, int'(ram_addr), m_ptr);
        chk({cur_req, " scan_tick"}, int'(scan_tick), int'(exp_tick()));
        cfg_we = we; cfg_addr = a; cfg_wdata = d; host_rd = rd; host_wr = wr;
        model_adv(we, a, d, rd, wr);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, 0, 0);
    endtask

    task automatic wr_ctrl(input bit [7:0] a, input bit [7:0] d);
        step(1, a, d, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 200000 && !done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 200000", cyc);
            finish_run();
        end
    end

    int hold_val;

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ram_addr", int'(ram_addr), 0);
        chk("R1 scan_tick", int'(scan_tick), 0);
        rst = 1'b0;
        model_adv(0, 8'h00, 8'h00, 0, 0);
        idle(20);

        // R2: misaddressed write with enable bits set
        cur_req = "R2";
        wr_ctrl(8'h11, 8'h7D);
        idle(100);
        chk("R2 no tick after misaddressed write", int'(scan_tick), 0);
        chk("R2 pointer unchanged", int'(ram_addr), 0);

        // R5/R6: scan up at /8, no auto-cycle, stop at 63
        cur_req = "R5";
        wr_ctrl(8'h10, 8'h7D);
        idle(400);
        cur_req = "R6";
        idle(200);
        chk("R6 stopped at top", int'(ram_addr), 63);

        // R7: scan down with auto-cycle, bounce at 0 and at 63
        cur_req = "R7";
        wr_ctrl(8'h10, 8'h7B);
        idle(1200);

        // R3: slowest and a middle rate
        cur_req = "R3";
        wr_ctrl(8'h10, 8'h45);
        idle(2100);
        wr_ctrl(8'h10, 8'h5D);
        idle(400);

        // R4: enable low, pointer holds
        cur_req = "R4";
        wr_ctrl(8'h10, 8'h5C);
        idle(2);
        hold_val = int'(ram_addr);
        idle(300);
        chk("R4 pointer holds with enable low", int'(ram_addr), hold_val);
        chk("R4 no tick with enable low", int'(scan_tick), 0);

        // R9: clear by write with access off
        cur_req = "R9";
        wr_ctrl(8'h10, 8'h00);
        idle(2);
        chk("R9 cleared", int'(ram_addr), 0);

        // R8: read strobes advance, write strobes ignored
        cur_req = "R8";
        wr_ctrl(8'h10, 8'hC0);
        for (int i = 0; i < 3; i++) step(0, 8'h00, 8'h00, 1, 0);
        for (int i = 0; i < 2; i++) step(0, 8'h00, 8'h00, 0, 1);
        idle(2);
        chk("R8 read-select steps", int'(ram_addr), 3);
        wr_ctrl(8'h10, 8'h40);
        for (int i = 0; i < 70; i++) step(0, 8'h00, 8'h00, 0, 1);
        for (int i = 0; i < 4; i++) step(0, 8'h00, 8'h00, 1, 0);
        idle(2);
        chk("R8 write-select steps with wrap", int'(ram_addr), 9);
        cur_req = "R9";
        wr_ctrl(8'h10, 8'h00);
        for (int i = 0; i < 5; i++) step(0, 8'h00, 8'h00, 1, 1);
        idle(2);
        chk("R9 strobes ignored with access off", int'(ram_addr), 0);

        // R10: host step overrides coincident ticks
        cur_req = "R10";
        wr_ctrl(8'h10, 8'h7D);
        for (int i = 0; i < 40; i++) step(0, 8'h00, 8'h00, 0, 1);
        idle(1);
        chk("R10 host steps only", int'(ram_addr), 40);

        // R11: direction taken from each control write
        cur_req = "R11";
        wr_ctrl(8'h10, 8'h79);
        idle(400);
        chk("R11 scanned down to bottom", int'(ram_addr), 0);
        wr_ctrl(8'h10, 8'h7F);
        idle(1100);

        finish_run();
    end

endmodule